// File: doc/BRIEF.md
# Register Write Stream Capture Encoder

This block sits beside an FM synthesis core and watches every register write that goes into it. While capture is armed, it turns the writes into a compact stream of byte pairs on a valid/ready output. Each pair is either a register write or a delay code. A full shadow copy of all 512 registers (two banks of 256) is kept at all times. Each register address is squeezed into a raw index below 127. The elapsed time between logged writes, counted in millisecond ticks, comes out as delay pairs ahead of the write. Capture begins only when a note is keyed on. It then replays the relevant shadow contents so that a player can rebuild the starting state. A long silence ends capture and the block waits for a fresh trigger. A small hardware-type flag records whether the stream needs a second bank or the extended register set.

The controller has seven states. OFF is entered while `arm` is low. WAIT is entered when `arm` rises. WAIT moves to DUMP on a trigger write. DUMP walks all 512 shadow entries and then goes to EMIT. RUN receives a write that is logged. From RUN the path is LONG, then SHORT, then EMIT, or any suffix of that path, depending on the elapsed time. The timeout path leads back to WAIT, or straight to DUMP if the late write is itself a trigger. EMIT pushes the pending write and returns to RUN. Dropping `arm` in any state other than OFF leads to OFF. Pairs wait in a small FIFO when the consumer stalls.

Top module: `regcap_encoder`

## Requirements
- R1: After reset, `out_valid` is 0, `hw_type` is 0 (single bank) and `overflow` is 0.
- R2: Raw index numbering counts up from 0. It starts with 0x01, 0x04, 0x05, 0x08 and 0xBD (indexes 0 to 4). Next, for each offset s from 0 to 23 with s mod 8 below 6, come 0x20+s, 0x40+s, 0x60+s, 0x80+s and 0xE0+s. Last, for each channel c from 0 to 8, come 0xA0+c, 0xB0+c and 0xC0+c. This gives N=122 mapped registers. A write pair is `out_idx` = {address bit 8, raw index[6:0]} and `out_val` = the written value.
- R3: While capturing, a write to an unmapped register produces no pair. So does a write whose value equals the shadow copy. While not armed, no write produces a pair.
- R4: Capture starts on a write with low address byte 0xB0 to 0xB8 and data bit 5 set. It also starts on a write to low byte 0xBD whose data bits 5:0 exceed 0x20. No other write starts it.
- R5: At start, the block emits every shadow register, visiting low byte 0 to 255 with bank 0 before bank 1. It skips unmapped registers, zero values and low bytes 0xB0 to 0xB8. The trigger register shows its value from before the trigger. The triggering write is emitted after the dump.
- R6: An elapsed time t in ms before a logged write is emitted first, as delay pairs. For t from 1 to 256 the pair is (N, t-1). For larger t the block emits (N+1, (t>>8)-1), removes that multiple of 256 and repeats. For t=0 no delay pair is emitted. Delay codes never carry bit 7.
- R7: If a logged write comes more than 30000 ms after the previous one, capture ends and that write emits nothing. The block then waits for a new trigger, unless that write is itself a trigger, in which case it restarts at once. Exactly 30000 ms is still encoded.
- R8: `hw_type` encoding is 0 for single, 1 for dual and 2 for extended. It becomes 1 when an emitted nonzero write hits 0x1B0 to 0x1B8 while it is 0. It becomes 2 when an emitted nonzero write hits 0x104 while shadow 0x105 is nonzero. It only returns to 0 when a capture starts.
- R9: While `out_valid` is high and `out_ready` is low, `out_idx` and `out_val` hold.
- R10: A write that arrives while the encoder is still dumping or emitting pairs (including while stalled on a full FIFO) is lost. It does not reach the shadow copy, and it sets `overflow`, which stays set until reset.
- R11: While `arm` is low, writes still update the shadow copy, but no pair is produced and no capture starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Capture enabled when high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 9 | Register address, bit 8 selects bank |
| wr_data | input | 8 | Register write value |
| ms_tick | input | 1 | One-cycle pulse per elapsed millisecond |
| out_valid | output | 1 | Pair available |
| out_ready | input | 1 | Consumer accepts pair |
| out_idx | output | 8 | First byte: raw index with bank bit, or delay code |
| out_val | output | 8 | Second byte: value or delay count |
| hw_type | output | 2 | Hardware type of the current capture |
| overflow | output | 1 | Sticky lost-write flag |

## Verification
The bench aims at the delay boundaries 256, 257, 512 and 30000 ms. An off-by-one in the encoder would emit a spurious second delay pair there, or a wrong count. At 30001 ms the capture must end; a design that got this wrong would keep streaming. A trigger on 0xBD must dump the old 0xBD value before the new one, and a design that read the updated shadow would emit the new value twice. A write to the same value must leave the delay counter running, or the next delay comes out short. The write lost during a stall must leave the shadow untouched, which the bench shows by writing the same value again and expecting it to be emitted.

// File: rtl/regcap_pkg.sv
package regcap_pkg;

    localparam int HEAD_REGS  = 5;
    localparam int OP_SLOTS   = 18;
    localparam int OP_GROUPS  = 5;
    localparam int CHANNELS   = 9;
    localparam int CH_GROUPS  = 3;
    localparam int CH_BASE    = HEAD_REGS + OP_SLOTS * OP_GROUPS;
    localparam int MAPPED     = CH_BASE + CHANNELS * CH_GROUPS;
    localparam logic [6:0] CODE_SHORT = 7'(MAPPED);
    localparam logic [6:0] CODE_LONG  = 7'(MAPPED + 1);
    localparam logic [7:0] NO_RAW     = 8'hFF;

    typedef enum logic [1:0] {
        HW_SINGLE = 2'd0,
        HW_DUAL   = 2'd1,
        HW_EXT    = 2'd2
    } hw_kind_e;

    typedef enum logic [2:0] {
        ST_OFF, ST_WAIT, ST_RUN, ST_DUMP, ST_LONG, ST_SHORT, ST_EMIT
    } cap_state_e;

    // Compress a register byte into its raw index, NO_RAW if not tracked.
    function automatic logic [7:0] reg_to_raw(input logic [7:0] r);
        logic [7:0] res;
        logic [2:0] grp;
        logic [4:0] slot;
        res  = NO_RAW;
        grp  = 3'd7;
        slot = 5'(r[4:3]) * 5'd6 + 5'(r[2:0]);
        case (r)
            8'h01:   res = 8'd0;
            8'h04:   res = 8'd1;
            8'h05:   res = 8'd2;
            8'h08:   res = 8'd3;
            8'hBD:   res = 8'd4;
            default: res = NO_RAW;
        endcase
        case (r[7:5])
            3'd1:    grp = 3'd0;
            3'd2:    grp = 3'd1;
            3'd3:    grp = 3'd2;
            3'd4:    grp = 3'd3;
            3'd7:    grp = 3'd4;
            default: grp = 3'd7;
        endcase
        if (grp != 3'd7 && r[4:3] != 2'b11 && r[2:0] < 3'd6)
            res = 8'(HEAD_REGS) + 8'(slot) * 8'(OP_GROUPS) + 8'(grp);
        if (r[7:4] >= 4'hA && r[7:4] <= 4'hC && r[3:0] <= 4'd8)
            res = 8'(CH_BASE) + 8'(r[3:0]) * 8'(CH_GROUPS) + 8'(r[7:4] - 4'hA);
        return res;
    endfunction

    function automatic logic is_note_reg(input logic [7:0] r);
        return (r >= 8'hB0) && (r <= 8'hB8);
    endfunction

endpackage

// File: rtl/regcap_msclock.sv
module regcap_msclock #(
    parameter int TIME_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              clear,
    output logic [TIME_W-1:0] elapsed
);
    localparam logic [TIME_W-1:0] CEIL = '1;

    always_ff @(posedge clk) begin
        if (!rst_n)
            elapsed <= '0;
        else if (clear)
            elapsed <= {{(TIME_W-1){1'b0}}, tick};
        else if (tick && elapsed != CEIL)
            elapsed <= elapsed + 1'b1;
    end
endmodule

// File: rtl/regcap_fifo.sv
module regcap_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] slots [DEPTH];
    logic [AW:0]      wp, rp;

    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign dout  = slots[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !full) begin
                slots[wp[AW-1:0]] <= din;
                wp <= wp + 1'b1;
            end
            if (pop && !empty)
                rp <= rp + 1'b1;
        end
    end
endmodule

// File: rtl/regcap_encoder.sv
module regcap_encoder
    import regcap_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int TIME_W     = 15,
    parameter int TIMEOUT_MS = 30000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic       wr_en,
    input  logic [8:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       ms_tick,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_idx,
    output logic [7:0] out_val,
    output logic [1:0] hw_type,
    output logic       overflow
);
    localparam int REGS = 512;
    localparam logic [TIME_W-1:0] SHORT_MAX = TIME_W'(256);
    localparam logic [TIME_W-1:0] TIMEOUT_T = TIME_W'(TIMEOUT_MS);
    localparam logic [8:0]        SCAN_LAST = 9'(REGS - 1);

    cap_state_e        state, state_nx;
    hw_kind_e          hw, hw_next;
    logic [7:0]        shadow [REGS];
    logic [8:0]        pend_addr, scan, scan_addr, hw_addr;
    logic [7:0]        pend_val, pend_old, hw_val;
    logic [TIME_W-1:0] remain, elapsed, long_units;
    logic [15:0]       push_pair, head;
    logic [7:0]        raw_w, pend_raw, scan_raw, dump_val;
    logic              take, push, fifo_full, fifo_empty;
    logic              cap_start, logged, scan_step, latch_pend, hw_set;
    logic              wr_mapped, wr_changed, wr_trig, scan_emit;

    // ---------------- write decode ----------------
    assign take       = wr_en && (state == ST_OFF || state == ST_WAIT || state == ST_RUN);
    assign raw_w      = reg_to_raw(wr_addr[7:0]);
    assign wr_mapped  = (raw_w != NO_RAW);
    assign wr_changed = (shadow[wr_addr] != wr_data);
    assign wr_trig    = (is_note_reg(wr_addr[7:0]) && wr_data[5]) ||
                        (wr_addr[7:0] == 8'hBD && wr_data[5:0] > 6'h20);

    // ---------------- dump walk ----------------
    assign scan_addr = {scan[0], scan[8:1]};
    assign scan_raw  = reg_to_raw(scan_addr[7:0]);
    assign dump_val  = (scan_addr == pend_addr) ? pend_old : shadow[scan_addr];
    assign scan_emit = (scan_raw != NO_RAW) && (dump_val != 8'd0) &&
                       !is_note_reg(scan_addr[7:0]);

    assign pend_raw   = reg_to_raw(pend_addr[7:0]);
    assign long_units = remain >> 8;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // ---------------- next state and controls ----------------
    always_comb begin
        state_nx   = state;
        push       = 1'b0;
        push_pair  = '0;
        cap_start  = 1'b0;
        logged     = 1'b0;
        scan_step  = 1'b0;
        latch_pend = 1'b0;
        hw_set     = 1'b0;
        hw_addr    = pend_addr;
        hw_val     = pend_val;
        unique case (state)
            ST_OFF: if (arm) state_nx = ST_WAIT;
            ST_WAIT: begin
                if (!arm) state_nx = ST_OFF;
                else if (wr_en && wr_trig) begin
                    cap_start  = 1'b1;
                    latch_pend = 1'b1;
                    state_nx   = ST_DUMP;
                end
            end
            ST_RUN: begin
                if (!arm) state_nx = ST_OFF;
                else if (wr_en && wr_mapped && wr_changed) begin
                    logged     = 1'b1;
                    latch_pend = 1'b1;
                    if (elapsed > TIMEOUT_T) begin
                        if (wr_trig) begin
                            cap_start = 1'b1;
                            state_nx  = ST_DUMP;
                        end else
                            state_nx  = ST_WAIT;
                    end
                    else if (elapsed > SHORT_MAX) state_nx = ST_LONG;
                    else if (elapsed != '0)       state_nx = ST_SHORT;
                    else                          state_nx = ST_EMIT;
                end
            end
            ST_DUMP: begin
                if (!arm) state_nx = ST_OFF;
                else if (!(scan_emit && fifo_full)) begin
                    scan_step = 1'b1;
                    if (scan_emit) begin
                        push      = 1'b1;
                        push_pair = {scan_addr[8], scan_raw[6:0], dump_val};
                        hw_set    = 1'b1;
                        hw_addr   = scan_addr;
                        hw_val    = dump_val;
                    end
                    if (scan == SCAN_LAST) state_nx = ST_EMIT;
                end
            end
            ST_LONG: begin
                if (!arm) state_nx = ST_OFF;
                else if (!fifo_full) begin
                    push      = 1'b1;
                    push_pair = {1'b0, CODE_LONG, 8'(long_units - 1'b1)};
                    state_nx  = (remain[7:0] != 8'd0) ? ST_SHORT : ST_EMIT;
                end
            end
            ST_SHORT: begin
                if (!arm) state_nx = ST_OFF;
                else if (!fifo_full) begin
                    push      = 1'b1;
                    push_pair = {1'b0, CODE_SHORT, 8'(remain - 1'b1)};
                    state_nx  = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (!arm) state_nx = ST_OFF;
                else if (!fifo_full) begin
                    push      = 1'b1;
                    push_pair = {pend_addr[8], pend_raw[6:0], pend_val};
                    hw_set    = 1'b1;
                    state_nx  = ST_RUN;
                end
            end
            default: state_nx = ST_OFF;
        endcase
    end

    // ---------------- hardware type rules ----------------
    always_comb begin
        hw_next = hw;
        if (hw != HW_EXT && hw_addr == 9'h104 && hw_val != 8'd0 && shadow[9'h105] != 8'd0)
            hw_next = HW_EXT;
        else if (hw == HW_SINGLE && hw_addr >= 9'h1B0 && hw_addr <= 9'h1B8 && hw_val != 8'd0)
            hw_next = HW_DUAL;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_addr <= '0;
            pend_val  <= '0;
            pend_old  <= '0;
            remain    <= '0;
            scan      <= '0;
            hw        <= HW_SINGLE;
            overflow  <= 1'b0;
        end else begin
            if (latch_pend) begin
                pend_addr <= wr_addr;
                pend_val  <= wr_data;
                pend_old  <= shadow[wr_addr];
                remain    <= elapsed;
            end else if (state == ST_LONG && push)
                remain <= remain & TIME_W'(255);
            if (cap_start)      scan <= '0;
            else if (scan_step) scan <= scan + 1'b1;
            if (cap_start)           hw <= HW_SINGLE;
            else if (hw_set && push) hw <= hw_next;
            if (wr_en && !take) overflow <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REGS; i++) shadow[i] <= 8'd0;
        end else if (take)
            shadow[wr_addr] <= wr_data;
    end

    // ---------------- submodules ----------------
    regcap_msclock #(.TIME_W(TIME_W)) u_clock (
        .clk(clk), .rst_n(rst_n), .tick(ms_tick),
        .clear(cap_start | logged), .elapsed(elapsed)
    );

    regcap_fifo #(.WIDTH(16), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(push_pair),
        .pop(out_ready), .dout(head), .full(fifo_full), .empty(fifo_empty)
    );

    assign out_valid = !fifo_empty;
    assign out_idx   = head[15:8];
    assign out_val   = head[7:0];
    assign hw_type   = hw;
endmodule

// File: rtl/regcap_checker.sv
module regcap_checker
    import regcap_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_idx,
    input logic [7:0] out_val,
    input logic [1:0] hw_type,
    input logic       overflow,
    input logic       cap_start
);
    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_idx) && $stable(out_val))); // R9

    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R10

    AST_HW_ONLY_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_start |=> (hw_type >= $past(hw_type))); // R8

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_idx[6:0] <= CODE_LONG) &&
                       !(out_idx[7] && out_idx[6:0] >= CODE_SHORT))); // R6
endmodule

bind regcap_encoder regcap_checker u_chk (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_idx(out_idx), .out_val(out_val), .hw_type(hw_type),
    .overflow(overflow), .cap_start(cap_start)
);

// File: tb/regcap_encoder_test.sv
module regcap_encoder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arm = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ms_tick = 1'b0;
    logic       out_ready = 1'b1;
    logic       out_valid, overflow;
    logic [7:0] out_idx, out_val;
    logic [1:0] hw_type;

    int checks = 0;
    int errors = 0;
    int n_map  = 0;
    logic [7:0]  bmap [256];
    logic [7:0]  sh   [512];
    logic [15:0] exp_q [$];
    string       tag_q [$];

    regcap_encoder uut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ms_tick(ms_tick), .out_valid(out_valid),
        .out_ready(out_ready), .out_idx(out_idx), .out_val(out_val),
        .hw_type(hw_type), .overflow(overflow)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compare each accepted pair with the scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0)
                chk(1'b0, "R3 unexpected pair", {out_idx, out_val}, 0);
            else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({out_idx, out_val} == e, t, {out_idx, out_val}, e);
            end
        end
    end

    task automatic put_map(input logic [7:0] r);
        bmap[r] = 8'(n_map);
        n_map++;
    endtask

    task automatic exp_pair(input logic [7:0] i, input logic [7:0] v, input string tag);
        exp_q.push_back({i, v});
        tag_q.push_back(tag);
    endtask

    task automatic exp_write(input logic [8:0] a, input logic [7:0] v, input string tag);
        exp_pair({a[8], bmap[a[7:0]][6:0]}, v, tag);
    endtask

    task automatic exp_delay(input int t_in);
        int t;
        t = t_in;
        while (t > 0) begin
            if (t <= 256) begin
                exp_pair(8'(n_map), 8'(t - 1), "R6 short delay");
                t = 0;
            end else begin
                int s;
                s = t >> 8;
                exp_pair(8'(n_map + 1), 8'(s - 1), "R6 long delay");
                t = t - (s << 8);
            end
        end
    endtask

    task automatic exp_dump(input logic [8:0] trig, input logic [7:0] old);
        for (int i = 0; i < 256; i++) begin
            for (int b = 0; b < 2; b++) begin
                logic [8:0] a;
                logic [7:0] v;
                a = 9'(b * 256 + i);
                v = (a == trig) ? old : sh[a];
                if (bmap[a[7:0]] != 8'hFF && v != 8'd0 && !(a[7:0] >= 8'hB0 && a[7:0] <= 8'hB8))
                    exp_pair({a[8], bmap[a[7:0]][6:0]}, v, "R5 dump");
            end
        end
    endtask

    task automatic drive(input logic [8:0] a, input logic [7:0] v);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(posedge clk); #1;
        wr_en = 1'b0;
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [8:0] a, input logic [7:0] v);
        drive(a, v);
        sh[a] = v;
    endtask

    task automatic ticks(input int n);
        @(posedge clk); #1;
        ms_tick = 1'b1;
        repeat (n) @(posedge clk);
        #1;
        ms_tick = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) bmap[i] = 8'hFF;
        for (int i = 0; i < 512; i++) sh[i] = 8'd0;
        put_map(8'h01); put_map(8'h04); put_map(8'h05); put_map(8'h08); put_map(8'hBD);
        for (int s = 0; s < 24; s++) begin
            if ((s % 8) < 6) begin
                put_map(8'(8'h20 + s)); put_map(8'(8'h40 + s)); put_map(8'(8'h60 + s));
                put_map(8'(8'h80 + s)); put_map(8'(8'hE0 + s));
            end
        end
        for (int c = 0; c < 9; c++) begin
            put_map(8'(8'hA0 + c)); put_map(8'(8'hB0 + c)); put_map(8'(8'hC0 + c));
        end

        settle(3);
        chk(out_valid == 1'b0, "R1 valid", out_valid, 0);
        chk(hw_type == 2'd0, "R1 hw_type", hw_type, 0);
        chk(overflow == 1'b0, "R1 overflow", overflow, 0);
        rst_n = 1'b1;
        settle(2);

        // R11: not armed, shadow fills, no pairs even on a note-on
        wr(9'h020, 8'h11); wr(9'h040, 8'h22); wr(9'h1E0, 8'h03);
        wr(9'h0FF, 8'h55); wr(9'h0B0, 8'h20);
        settle(4);
        chk(out_valid == 1'b0, "R11 disarmed output", out_valid, 0);

        arm = 1'b1;
        settle(2);
        // R4: 0xBD with low bits exactly 0x20 and a plain write do not start
        wr(9'h0BD, 8'h20); wr(9'h0A0, 8'h44);
        settle(4);
        chk(out_valid == 1'b0, "R4 no trigger", out_valid, 0);

        // R4/R5: note-on on channel 1 starts capture
        exp_dump(9'h0B1, sh[9'h0B1]);
        exp_write(9'h0B1, 8'h31, "R4 trigger write");
        wr(9'h0B1, 8'h31);
        settle(600);
        chk(hw_type == 2'd0, "R8 single after start", hw_type, 0);

        // R6: 5 ms before a write
        ticks(5);
        exp_delay(5); exp_write(9'h040, 8'h23, "R2 write");
        wr(9'h040, 8'h23);
        // R3: equal value and unmapped dropped, timer keeps running
        ticks(3);
        wr(9'h040, 8'h23);
        wr(9'h009, 8'h77);
        settle(4);
        chk(exp_q.size() == 0, "R3 dropped writes", exp_q.size(), 0);
        ticks(2);
        exp_delay(5); exp_write(9'h060, 8'h07, "R3 timer not reset");
        wr(9'h060, 8'h07);
        // R6: zero delay
        exp_write(9'h080, 8'h01, "R6 zero delay");
        wr(9'h080, 8'h01);
        // R6 boundaries
        ticks(256); exp_delay(256); exp_write(9'h021, 8'h05, "R6 t=256");
        wr(9'h021, 8'h05);
        ticks(257); exp_delay(257); exp_write(9'h022, 8'h06, "R6 t=257");
        wr(9'h022, 8'h06);
        ticks(512); exp_delay(512); exp_write(9'h0C0, 8'h0E, "R6 t=512");
        wr(9'h0C0, 8'h0E);
        settle(6);

        // R8: second bank key-on, then extended enable
        exp_write(9'h1B2, 8'h01, "R8 bank1 write");
        wr(9'h1B2, 8'h01);
        settle(3);
        chk(hw_type == 2'd1, "R8 dual", hw_type, 1);
        exp_write(9'h105, 8'h01, "R8 write 105");
        wr(9'h105, 8'h01);
        exp_write(9'h104, 8'h03, "R8 write 104");
        wr(9'h104, 8'h03);
        settle(3);
        chk(hw_type == 2'd2, "R8 extended", hw_type, 2);
        settle(6);

        // R9/R10: stall the output
        out_ready = 1'b0;
        for (int k = 0; k < 5; k++) begin
            exp_write(9'(9'h080 + k), 8'(8'h30 + k), "R9 stalled write");
            wr(9'(9'h080 + k), 8'(8'h30 + k));
        end
        chk(out_valid == 1'b1, "R9 valid while stalled", out_valid, 1);
        chk(out_idx == {1'b0, bmap[8'h80][6:0]}, "R9 head held", out_idx, bmap[8'h80]);
        drive(9'h085, 8'h35);
        chk(overflow == 1'b1, "R10 overflow", overflow, 1);
        out_ready = 1'b1;
        settle(12);
        exp_write(9'h085, 8'h35, "R10 lost write left shadow");
        wr(9'h085, 8'h35);
        settle(6);
        chk(overflow == 1'b1, "R10 sticky", overflow, 1);

        // R6/R7: exactly 30000 ms still encoded
        ticks(30000); exp_delay(30000); exp_write(9'h043, 8'h0B, "R7 t=30000");
        wr(9'h043, 8'h0B);
        settle(6);
        // R7: 30001 ms ends capture
        ticks(30001);
        wr(9'h044, 8'h09);
        ticks(2);
        wr(9'h045, 8'h06);
        settle(4);
        chk(out_valid == 1'b0, "R7 capture ended", out_valid, 0);
        // R5: restart on 0xBD trigger, dump shows the old 0xBD value
        exp_dump(9'h0BD, sh[9'h0BD]);
        exp_write(9'h0BD, 8'h21, "R5 trigger after dump");
        wr(9'h0BD, 8'h21);
        settle(600);
        chk(hw_type == 2'd2, "R8 extended rebuilt from dump", hw_type, 2);

        // R11: disarm, nothing further
        arm = 1'b0;
        settle(2);
        wr(9'h0B3, 8'h20);
        settle(6);
        chk(out_valid == 1'b0, "R11 disarmed again", out_valid, 0);
        chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule